// File: doc/BRIEF.md
# Tuning tap window selector

This block chooses a sampling tap for a high-speed card interface once a tuning sweep is over. The sweep probes each of N taps twice, so it yields two vectors of 2×N bits. In the probe vector a bit is one when the tuning probe at that position succeeded. In the match vector a bit is one when the sampled-data comparison agreed. Bit i of either vector belongs to tap (i mod N).

A start pulse loads both vectors and the tap count. The block then works through the positions in sequence, one position per cycle. First it combines the two halves of each vector, so that a tap counts as good only when both of its probes were good. It then searches the combined probe vector for the longest run of ones. If every position passed, the data-compare vector decides instead. The chosen tap is the midpoint of the winning run, folded back into the range 0 to N-1.

The result comes with a one-cycle done strobe. On success the block raises an auto-retune enable. On failure it raises an error flag and keeps the previous tap. A retune-request status bit is cleared when a selection starts.

Top module: `tune_tap_select`

## Requirements
- R1: After reset, done, sel_err, retune_en and retune_req are 0 and tap_sel is 0.
- R2: A start with tap_count equal to 0, or with 2×tap_count at least VEC_W, ends with done and sel_err at 1, retune_en at 0 and tap_sel unchanged.
- R3: The two vectors are combined separately. Tap t (t < N) stays good at positions t and t+N only when both of those original bits are 1. Otherwise both positions become 0.
- R4: The block finds the longest run of ones in the combined probe vector over positions 0 to 2N-1. A run that reaches position 2N-1 counts. On equal lengths the earliest run wins. The tap is ((first+last)/2) mod N with integer division.
- R5: If the longest probe run is shorter than 2N and shorter than MIN_RUN (3), done comes with sel_err at 1, retune_en at 0 and tap_sel unchanged.
- R6: If the longest probe run covers all 2N positions, the run search of R4 is applied to the combined match vector instead. A zero-length result is a failure, reported as in R5.
- R7: On success, done comes with sel_err at 0, retune_en at 1 and the new tap_sel. Accepting a start clears retune_en.
- R8: retune_req becomes 1 in the cycle after req_set is high. It is cleared when a start is accepted, and that clear wins over req_set in the same cycle.
- R9: done is high for exactly one cycle per accepted start. A start that arrives while a selection is running is ignored.
- R10: Bits at positions 2N and above in either input vector have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection (accepted when idle) |
| tap_count | input | IDX_W+1 | Number of taps N |
| probe_ok | input | VEC_W | Per-position tuning probe success |
| match_ok | input | VEC_W | Per-position sampled-data match |
| req_set | input | 1 | Sets the retune-request status bit |
| done | output | 1 | One-cycle completion strobe |
| sel_err | output | 1 | Selection failed |
| tap_sel | output | IDX_W | Selected tap |
| retune_en | output | 1 | Auto-retune enable |
| retune_req | output | 1 | Retune-request status bit |

## Verification
The bench builds the block with its default parameters, VEC_W of 32 and MIN_RUN of 3. That supports tap counts from 1 to 15 and lets the tests reach the rejection of 16 as well as the largest legal count of 15. Directed patterns cover the following cases:
- a good window near the start of the sweep
- a window that wraps from the last taps to the first
- taps that pass in only one half of the sweep
- runs of equal length
- a run one position short of the minimum
- the all-pass fallback to the match vector, both with and without a match
- junk bits above position 2N

A further test sends a second start during a run. It must be ignored.

// File: rtl/tune_tap_select_pkg.sv
package tune_tap_select_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MERGE,
    ST_SCAN_P,
    ST_PICK_P,
    ST_SCAN_M,
    ST_PICK_M,
    ST_FAIL
  } tsel_state_t;
endpackage

// File: rtl/tsel_merge_step.sv
// One position of the half-combining pass: a zero at position idx
// knocks out both copies of its tap.
module tsel_merge_step #(
  parameter int VEC_W = 32,
  localparam int SEL_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] vec_in,
  input  logic [SEL_W-1:0] idx,
  input  logic [SEL_W-1:0] tap_idx,
  input  logic [SEL_W-1:0] n_taps,
  output logic [VEC_W-1:0] vec_out
);
  logic [SEL_W-1:0] twin_idx;

  always_comb begin
    twin_idx = tap_idx + n_taps;
    vec_out  = vec_in;
    if (!vec_in[idx]) begin
      vec_out[tap_idx]  = 1'b0;
      vec_out[twin_idx] = 1'b0;
    end
  end
endmodule

// File: rtl/tsel_run_scan.sv
// Serial longest-run tracker. The caller feeds one position per step and a
// final step at pos = 2N with bit_in = 0 to close a run still open.
module tsel_run_scan #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             bit_in,
  input  logic [IDX_W-1:0] pos,
  output logic [IDX_W-1:0] best_len,
  output logic [IDX_W-1:0] best_first,
  output logic [IDX_W-1:0] best_last
);
  logic [IDX_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_len    <= '0;
      best_len   <= '0;
      best_first <= '0;
      best_last  <= '0;
    end else if (step) begin
      if (bit_in) begin
        run_len <= run_len + 1'b1;
      end else begin
        if (run_len > best_len) begin
          best_len   <= run_len;
          best_first <= pos - run_len;
          best_last  <= pos - 1'b1;
        end
        run_len <= '0;
      end
    end
  end
endmodule

// File: rtl/tsel_tap_pick.sv
// Midpoint of a run folded into 0..N-1. Inputs are below 2N, so one
// conditional subtraction performs the modulo.
module tsel_tap_pick #(
  parameter int IDX_W = 6,
  localparam int SEL_W = IDX_W - 1
) (
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] last,
  input  logic [SEL_W-1:0] n_taps,
  output logic [IDX_W-1:0] tap
);
  logic [IDX_W:0] sum;
  logic [IDX_W:0] half;
  logic [IDX_W:0] n_ext;

  always_comb begin
    sum   = {1'b0, first} + {1'b0, last};
    half  = sum >> 1;
    n_ext = (IDX_W + 1)'(n_taps);
    if (half >= n_ext) tap = IDX_W'(half - n_ext);
    else               tap = half[IDX_W-1:0];
  end
endmodule

// File: rtl/tune_tap_select.sv
module tune_tap_select
  import tune_tap_select_pkg::*;
#(
  parameter int VEC_W   = 32,
  parameter int MIN_RUN = 3,
  localparam int SEL_W = $clog2(VEC_W),
  localparam int IDX_W = SEL_W + 1,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] tap_count,
  input  logic [VEC_W-1:0] probe_ok,
  input  logic [VEC_W-1:0] match_ok,
  input  logic             req_set,
  output logic             done,
  output logic             sel_err,
  output logic [IDX_W-1:0] tap_sel,
  output logic             retune_en,
  output logic             retune_req
);
  tsel_state_t state;

  logic [VEC_W-1:0] pvec, mvec, pvec_nx, mvec_nx, in_mask;
  logic [SEL_W-1:0] n_r;
  logic [IDX_W-1:0] two_n;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] idx_mod;
  logic             busy, accept, count_bad;
  logic             scan_clr, scan_step, scan_bit;
  logic [IDX_W-1:0] best_len, best_first, best_last, pick_tap;
  logic [CNT_W:0]   two_n_in;

  assign busy   = (state != ST_IDLE);
  assign accept = start && !busy;
  assign two_n  = {n_r, 1'b0};

  // Tap-count check and mask for positions above 2N
  always_comb begin
    two_n_in  = {tap_count, 1'b0};
    count_bad = (tap_count == '0) || (two_n_in >= (CNT_W + 1)'(VEC_W));
    for (int k = 0; k < VEC_W; k++) begin
      in_mask[k] = ((CNT_W + 1)'(k) < two_n_in);
    end
  end

  tsel_merge_step #(.VEC_W(VEC_W)) u_merge_p (
    .vec_in(pvec), .idx(idx[SEL_W-1:0]), .tap_idx(idx_mod),
    .n_taps(n_r), .vec_out(pvec_nx)
  );

  tsel_merge_step #(.VEC_W(VEC_W)) u_merge_m (
    .vec_in(mvec), .idx(idx[SEL_W-1:0]), .tap_idx(idx_mod),
    .n_taps(n_r), .vec_out(mvec_nx)
  );

  assign scan_clr  = (state == ST_IDLE) || (state == ST_PICK_P);
  assign scan_step = (state == ST_SCAN_P) || (state == ST_SCAN_M);

  always_comb begin
    if (idx == two_n)            scan_bit = 1'b0;
    else if (state == ST_SCAN_M) scan_bit = mvec[idx[SEL_W-1:0]];
    else                         scan_bit = pvec[idx[SEL_W-1:0]];
  end

  tsel_run_scan #(.IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst(rst), .clr(scan_clr), .step(scan_step),
    .bit_in(scan_bit), .pos(idx),
    .best_len(best_len), .best_first(best_first), .best_last(best_last)
  );

  tsel_tap_pick #(.IDX_W(IDX_W)) u_pick (
    .first(best_first), .last(best_last), .n_taps(n_r), .tap(pick_tap)
  );

  // Retune-request status: cleared when a selection is accepted
  always_ff @(posedge clk) begin
    if (rst)          retune_req <= 1'b0;
    else if (accept)  retune_req <= 1'b0;
    else if (req_set) retune_req <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pvec      <= '0;
      mvec      <= '0;
      n_r       <= '0;
      idx       <= '0;
      idx_mod   <= '0;
      done      <= 1'b0;
      sel_err   <= 1'b0;
      tap_sel   <= '0;
      retune_en <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            retune_en <= 1'b0;
            sel_err   <= 1'b0;
            idx       <= '0;
            idx_mod   <= '0;
            if (count_bad) begin
              state <= ST_FAIL;
            end else begin
              pvec  <= probe_ok & in_mask;
              mvec  <= match_ok & in_mask;
              n_r   <= tap_count[SEL_W-1:0];
              state <= ST_MERGE;
            end
          end
        end
        ST_MERGE: begin
          pvec <= pvec_nx;
          mvec <= mvec_nx;
          if (idx_mod == n_r - 1'b1) idx_mod <= '0;
          else                       idx_mod <= idx_mod + 1'b1;
          if (idx == two_n - 1'b1) begin
            idx   <= '0;
            state <= ST_SCAN_P;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_SCAN_P, ST_SCAN_M: begin
          if (idx == two_n) begin
            idx   <= '0;
            state <= (state == ST_SCAN_P) ? ST_PICK_P : ST_PICK_M;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PICK_P: begin
          if (best_len == two_n) begin
            state <= ST_SCAN_M;
          end else if (best_len >= IDX_W'(MIN_RUN)) begin
            done      <= 1'b1;
            tap_sel   <= pick_tap;
            retune_en <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_FAIL;
          end
        end
        ST_PICK_M: begin
          if (best_len != '0) begin
            done      <= 1'b1;
            tap_sel   <= pick_tap;
            retune_en <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_FAIL;
          end
        end
        ST_FAIL: begin
          done    <= 1'b1;
          sel_err <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tune_tap_select_chk.sv
module tune_tap_select_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             req_set,
  input logic             done,
  input logic             sel_err,
  input logic [IDX_W-1:0] tap_sel,
  input logic             retune_en,
  input logic             retune_req
);
  // R1
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!done && !sel_err && !retune_en && !retune_req && tap_sel == '0));

  // R9
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  assert_err_keeps_tap_R5: assert property (@(posedge clk) disable iff (rst)
    (done && sel_err) |-> (tap_sel == $past(tap_sel) && !retune_en));

  // R7
  assert_success_retune_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !sel_err) |-> retune_en);

  // R7
  assert_tap_only_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(tap_sel));

  // R8
  assert_req_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> !retune_req);

  // R8
  assert_req_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (req_set && !(start && !busy)) |=> retune_req);
endmodule

bind tune_tap_select tune_tap_select_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .req_set(req_set),
  .done(done), .sel_err(sel_err), .tap_sel(tap_sel),
  .retune_en(retune_en), .retune_req(retune_req)
);

// File: tb/tune_tap_select_test.sv
module tune_tap_select_test;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 32;
  localparam int IDX_W = $clog2(VEC_W) + 1;
  localparam int CNT_W = IDX_W + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [CNT_W-1:0] tap_count = '0;
  logic [VEC_W-1:0] probe_ok = '0;
  logic [VEC_W-1:0] match_ok = '0;
  logic             req_set = 1'b0;
  logic             done, sel_err, retune_en, retune_req;
  logic [IDX_W-1:0] tap_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tune_tap_select #(.VEC_W(VEC_W), .MIN_RUN(3)) uut (
    .clk(clk), .rst(rst), .start(start), .tap_count(tap_count),
    .probe_ok(probe_ok), .match_ok(match_ok), .req_set(req_set),
    .done(done), .sel_err(sel_err), .tap_sel(tap_sel),
    .retune_en(retune_en), .retune_req(retune_req)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference selection computed from the requirements
  task automatic model(input int n, input logic [31:0] p, input logic [31:0] m,
                       output bit ok, output int tap);
    logic [31:0] pc, mc;
    int best, bs, be;
    pc = '0; mc = '0; ok = 0; tap = 0;
    if (n == 0 || 2 * n >= VEC_W) return;
    for (int t = 0; t < n; t++) begin
      if (p[t] && p[t + n]) begin pc[t] = 1; pc[t + n] = 1; end
      if (m[t] && m[t + n]) begin mc[t] = 1; mc[t + n] = 1; end
    end
    longest(pc, 2 * n, best, bs, be);
    if (best == 2 * n) begin
      longest(mc, 2 * n, best, bs, be);
      ok = (best != 0);
    end else begin
      ok = (best >= 3);
    end
    if (ok) tap = ((bs + be) / 2) % n;
  endtask

  task automatic longest(input logic [31:0] v, input int len,
                         output int best, output int bs, output int be);
    int run;
    best = 0; bs = 0; be = 0; run = 0;
    for (int i = 0; i <= len; i++) begin
      if (i < len && v[i]) run++;
      else begin
        if (run > best) begin best = run; bs = i - run; be = i - 1; end
        run = 0;
      end
    end
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 0;
    for (int c = 0; c < 200 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(req, "done seen", int'(seen), 1);
  endtask

  task automatic run_case(input string req, input int n,
                          input logic [31:0] p, input logic [31:0] m);
    bit ok, seen;
    int tap, prev;
    model(n, p, m, ok, tap);
    prev = int'(tap_sel);
    @(negedge clk);
    tap_count = CNT_W'(n); probe_ok = p; match_ok = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, "retune_en cleared on start", int'(retune_en), 0);
    wait_done(req, seen);
    if (seen) begin
      check(req, "sel_err", int'(sel_err), ok ? 0 : 1);
      check(req, "retune_en", int'(retune_en), ok ? 1 : 0);
      check(req, "tap_sel", int'(tap_sel), ok ? tap : prev);
      @(negedge clk);
      check("R9", "done single cycle", int'(done), 0);
    end
  endtask

  task automatic test_reset();
    check("R1", "done", int'(done), 0);
    check("R1", "sel_err", int'(sel_err), 0);
    check("R1", "retune_en", int'(retune_en), 0);
    check("R1", "retune_req", int'(retune_req), 0);
    check("R1", "tap_sel", int'(tap_sel), 0);
  endtask

  task automatic test_early_window();   // R4: taps 2..6 good, tie keeps first
    run_case("R4", 8, 32'h0000_7C7C, 32'h0);
    check("R4", "tap value", int'(tap_sel), 4);
  endtask

  task automatic test_wrap_window();    // R4: taps 6,7,0,1 good
    run_case("R4", 8, 32'h0000_C3C3, 32'h0);
    check("R4", "wrap tap value", int'(tap_sel), 7);
  endtask

  task automatic test_half_only();      // R3: taps 1..5 pass only in second half
    run_case("R3", 8, 32'h0000_3E00 | 32'h0000_0001 | 32'h0000_0100 |
             32'h0000_0080 | 32'h0000_8000 | 32'h0000_0040 | 32'h0000_4000, 32'h0);
    check("R3", "tap from combined taps 6,7,0", int'(tap_sel), 7);
  endtask

  task automatic test_short_run();      // R5: run of 2 fails
    run_case("R5", 8, 32'h0000_0C0C, 32'h0);
    check("R5", "sel_err short run", int'(sel_err), 1);
  endtask

  task automatic test_all_pass_match(); // R6: match taps 1..3
    run_case("R6", 8, 32'h0000_FFFF, 32'h0000_0E0E);
    check("R6", "tap from match", int'(tap_sel), 2);
  endtask

  task automatic test_all_pass_nomatch(); // R6: match vector empty after combining
    run_case("R6", 8, 32'h0000_FFFF, 32'h0000_00F0);
    check("R6", "sel_err no match", int'(sel_err), 1);
  endtask

  task automatic test_bad_counts();     // R2
    run_case("R2", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R2", "zero count err", int'(sel_err), 1);
    run_case("R2", 16, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R2", "count 16 err", int'(sel_err), 1);
    run_case("R2", 15, 32'h3FFF_FFFF, 32'h3FFF_FFFF);
    check("R2", "count 15 accepted", int'(sel_err), 0);
  endtask

  task automatic test_upper_ignored();  // R10: N=4, taps 1..3 good, junk above bit 7
    run_case("R10", 4, 32'hFFFF_FFEE, 32'hA5A5_A500);
    check("R10", "upper bits ignored", int'(tap_sel), 2);
  endtask

  task automatic test_one_tap();        // R6: N=1, both pass and match
    run_case("R6", 1, 32'h3, 32'h3);
    check("R6", "single tap", int'(tap_sel), 0);
  endtask

  task automatic test_req_and_busy();   // R8 and R9
    bit seen;
    @(negedge clk);
    req_set = 1'b1;
    @(negedge clk);
    req_set = 1'b0;
    check("R8", "retune_req set", int'(retune_req), 1);
    tap_count = CNT_W'(8); probe_ok = 32'h0000_3C3C; match_ok = 32'h0; start = 1'b1;
    req_set = 1'b1;
    @(negedge clk);
    start = 1'b0; req_set = 1'b0;
    check("R8", "retune_req cleared by start", int'(retune_req), 0);
    repeat (3) @(negedge clk);
    tap_count = CNT_W'(8); probe_ok = 32'h0000_FFFF; match_ok = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R9", seen);
    if (seen) begin
      check("R9", "busy start ignored err", int'(sel_err), 0);
      check("R9", "busy start ignored tap", int'(tap_sel), 3);
    end
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (done) check("R9", "no second done", 1, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check("WD", "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_early_window();
    test_wrap_window();
    test_half_only();
    test_short_run();
    test_all_pass_match();
    test_all_pass_nomatch();
    test_bad_counts();
    test_upper_ignored();
    test_one_tap();
    test_req_and_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule